// File: doc/BRIEF.md
# Supply power-good monitor

This block watches the output of a multi-phase step-down regulator and reports whether it is inside its window. A 5-bit voltage identification code selects the target level. The codes count downward from 1.850 V in 25 mV steps, and the all-ones code switches the output off. A digitised feedback sample in millivolts is compared against a fixed percentage of the decoded target. The result drives a flag that is high while the supply is good and low while it is bad. The decoded target is also presented as an output.

The two directions of the flag behave differently:
- **Bad to good.** Recovery is reported as soon as the compare passes.
- **Good to bad.** A fault is reported only after the feedback has stayed out of window for a whole run of time ticks. This keeps brief dips and code changes from pulsing the flag.
- **Disable or off.** Disabling the output, or selecting the off code, pulls the flag low at once.

The flag is a report only. Nothing in the block feeds back into regulation.

Every interface of this block is a plain level or strobe sampled on each clock. There is no stream traffic, so there is no valid/ready handshake and no back-pressure.

Top module: `pg_monitor`

## Requirements
- R1: For a code value N other than 31, the setpoint output equals 1100 + (30 - N) * 25 millivolts. Code 30 gives 1100, code 15 gives 1475 and code 0 gives 1850.
- R2: Code 31 (all ones) is the off code. It gives a setpoint output of 0, and two clocks after it is applied the flag is low, with no tick needed.
- R3: The feedback counts as in window when fb_mv * 100 >= setpoint * THR_PCT, so equality counts as good. THR_PCT defaults to 88, and the intended range is 85 to 92.
- R4: When the block is enabled, the code is not 31 and the feedback is in window, the flag is high on the second clock edge after those inputs are applied. No tick is involved.
- R5: While the flag is high and the inputs are out of window, the flag falls on the clock edge that samples the DELAY_TICKS-th tick seen since the condition began. Ticks sampled before the condition reached the compare stage do not count.
- R6: A single clock cycle of in-window feedback while the flag is high clears the tick count. A later fault then needs DELAY_TICKS new ticks before the flag falls.
- R7: When enable is low, the flag is low two clocks later without any delay, and it stays low for as long as enable stays low.
- R8: After reset the flag is low and the setpoint output is 0.
- R9: The setpoint output follows a code change on the first clock edge after the change, in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_code | input | 5 | Voltage identification code, descending map, 31 = off |
| fb_mv | input | MV_W | Feedback sample in millivolts |
| enable | input | 1 | Output enabled when high |
| tick | input | 1 | One-cycle time strobe (one per microsecond in use) |
| pg_ok | output | 1 | High = supply good, low = supply bad |
| setpoint_mv | output | MV_W | Decoded target in millivolts, 0 when off |

## Verification
The bench builds the block with DELAY_TICKS = 6, not the default of 500, and keeps MV_W = 12 and THR_PCT = 88. With the short window, complete fault delays, restarts after a one-cycle recovery, and falls that coincide with code changes or disables all occur many times within a few thousand cycles. Random ticks arrive on about one cycle in three, so every tick count up to the limit is reached. The feedback is drawn from a band of 85 to 101 percent of the setpoint, so the exact threshold equality is crossed often.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam logic [4:0]  VID_OFF     = 5'h1F;
  localparam int unsigned SP_BASE_MV  = 1100;
  localparam int unsigned SP_STEP_MV  = 25;
  localparam int unsigned SP_TOP_CODE = 30;

  // Descending code map: highest live code is the lowest voltage.
  function automatic logic [31:0] vid_to_mv(input logic [4:0] code);
    logic [31:0] steps;
    if (code == VID_OFF) return 32'd0;
    steps = 32'(SP_TOP_CODE) - 32'(code);
    return 32'(SP_BASE_MV) + steps * 32'(SP_STEP_MV);
  endfunction

  typedef struct packed {
    logic force_low;
    logic in_spec;
  } pgm_stage_t;
endpackage

// File: rtl/pgm_vid_decode.sv
module pgm_vid_decode #(
  parameter int unsigned MV_W = 12
) (
  input  logic [4:0]      vid_code,
  output logic [MV_W-1:0] target_mv,
  output logic            is_off
);
  import pgm_pkg::*;
  logic [31:0] full_mv;

  always_comb begin
    full_mv   = vid_to_mv(vid_code);
    target_mv = full_mv[MV_W-1:0];
    is_off    = (vid_code == VID_OFF);
  end
endmodule

// File: rtl/pgm_thresh_stage.sv
module pgm_thresh_stage #(
  parameter int unsigned MV_W    = 12,
  parameter int unsigned THR_PCT = 88
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MV_W-1:0]    fb_mv,
  input  logic [MV_W-1:0]    target_mv,
  input  logic               is_off,
  input  logic               enable,
  output pgm_pkg::pgm_stage_t stage_q,
  output logic [MV_W-1:0]    target_q
);
  import pgm_pkg::*;
  localparam int unsigned PROD_W = MV_W + 8;

  logic [PROD_W-1:0] fb_scaled;
  logic [PROD_W-1:0] sp_scaled;
  pgm_stage_t        stage_d;

  always_comb begin
    fb_scaled         = PROD_W'(fb_mv) * PROD_W'(100);
    sp_scaled         = PROD_W'(target_mv) * PROD_W'(THR_PCT);
    stage_d.force_low = is_off | ~enable;
    stage_d.in_spec   = (fb_scaled >= sp_scaled);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '{force_low: 1'b1, in_spec: 1'b0};
      target_q <= '0;
    end else begin
      stage_q  <= stage_d;
      target_q <= target_mv;
    end
  end
endmodule

// File: rtl/pgm_fall_timer.sv
module pgm_fall_timer #(
  parameter int unsigned DELAY_TICKS = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pgm_pkg::pgm_stage_t stage_q,
  input  logic               tick,
  output logic               flag_q
);
  localparam int unsigned CNT_W = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

  logic [CNT_W-1:0] bad_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      bad_cnt <= '0;
    end else if (stage_q.force_low) begin
      flag_q  <= 1'b0;
      bad_cnt <= '0;
    end else if (stage_q.in_spec) begin
      flag_q  <= 1'b1;
      bad_cnt <= '0;
    end else if (flag_q && tick) begin
      if (bad_cnt == LAST) begin
        flag_q  <= 1'b0;
        bad_cnt <= '0;
      end else begin
        bad_cnt <= bad_cnt + 1'b1;
      end
    end else if (!flag_q) begin
      bad_cnt <= '0;
    end
  end
endmodule

// File: rtl/pg_monitor.sv
module pg_monitor #(
  parameter int unsigned MV_W        = 12,
  parameter int unsigned THR_PCT     = 88,
  parameter int unsigned DELAY_TICKS = 500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      vid_code,
  input  logic [MV_W-1:0] fb_mv,
  input  logic            enable,
  input  logic            tick,
  output logic            pg_ok,
  output logic [MV_W-1:0] setpoint_mv
);
  import pgm_pkg::*;

  logic [MV_W-1:0] dec_mv;
  logic            dec_off;
  pgm_stage_t      stage_q;

  pgm_vid_decode #(.MV_W(MV_W)) u_decode (
    .vid_code (vid_code),
    .target_mv(dec_mv),
    .is_off   (dec_off)
  );

  pgm_thresh_stage #(.MV_W(MV_W), .THR_PCT(THR_PCT)) u_thresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .fb_mv    (fb_mv),
    .target_mv(dec_mv),
    .is_off   (dec_off),
    .enable   (enable),
    .stage_q  (stage_q),
    .target_q (setpoint_mv)
  );

  pgm_fall_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .stage_q(stage_q),
    .tick   (tick),
    .flag_q (pg_ok)
  );
endmodule

// File: rtl/pg_monitor_checker.sv
module pg_monitor_checker #(
  parameter int unsigned MV_W    = 12,
  parameter int unsigned THR_PCT = 88
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      vid_code,
  input logic [MV_W-1:0] fb_mv,
  input logic            enable,
  input logic            tick,
  input logic            pg_ok,
  input logic [MV_W-1:0] setpoint_mv
);
  logic [31:0] want_mv;
  logic        kill_in;
  logic        good_in;

  always_comb begin
    want_mv = (vid_code == 5'h1F) ? 32'd0 : (32'd1850 - 32'(vid_code) * 32'd25);
    kill_in = !enable || (vid_code == 5'h1F);
    good_in = !kill_in && (32'(fb_mv) * 32'd100 >= want_mv * 32'(THR_PCT));
  end

  AST_SETPOINT_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (32'(setpoint_mv) == $past(want_mv))) else $error("setpoint"); // R1

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_code == 5'h1F) |=> (setpoint_mv == '0)) else $error("off sp"); // R2

  AST_KILL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    kill_in |=> ##1 !pg_ok) else $error("kill"); // R7

  AST_RISE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    good_in |=> ##1 pg_ok) else $error("rise"); // R4

  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_ok) |-> ($past(tick) || $past(kill_in, 2))) else $error("fall"); // R5
endmodule

bind pg_monitor pg_monitor_checker #(.MV_W(MV_W), .THR_PCT(THR_PCT)) u_pgm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vid_code   (vid_code),
  .fb_mv      (fb_mv),
  .enable     (enable),
  .tick       (tick),
  .pg_ok      (pg_ok),
  .setpoint_mv(setpoint_mv)
);

// File: tb/pg_monitor_tb_top.sv
module pg_monitor_tb_top;
  localparam int MV_W = 12;
  localparam int THR  = 88;
  localparam int DLY  = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      vid_code = 5'd15;
  logic [MV_W-1:0] fb_mv = '0;
  logic            enable = 1'b0;
  logic            tick = 1'b0;
  logic            pg_ok;
  logic [MV_W-1:0] setpoint_mv;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pg_monitor #(.MV_W(MV_W), .THR_PCT(THR), .DELAY_TICKS(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .vid_code(vid_code), .fb_mv(fb_mv),
    .enable(enable), .tick(tick), .pg_ok(pg_ok), .setpoint_mv(setpoint_mv)
  );

  function automatic int exp_sp(input logic [4:0] c);
    if (c == 5'd31) return 0;
    return 1100 + (30 - int'(c)) * 25;
  endfunction

  function automatic bit exp_good(input logic [4:0] c, input int fb, input bit en);
    if (!en || c == 5'd31) return 1'b0;
    return (fb * 100 >= exp_sp(c) * THR);
  endfunction

  // Reference from the requirements: one compare stage, then the flag.
  int m_sp;
  bit m_good, m_kill, m_pg;
  int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sp <= 0; m_good <= 0; m_kill <= 1; m_pg <= 0; m_cnt <= 0;
    end else begin
      m_sp   <= exp_sp(vid_code);
      m_good <= exp_good(vid_code, int'(fb_mv), enable);
      m_kill <= !enable || vid_code == 5'd31;
      if (m_kill) begin m_pg <= 0; m_cnt <= 0; end
      else if (m_good) begin m_pg <= 1; m_cnt <= 0; end
      else if (m_pg && tick) begin
        if (m_cnt + 1 == DLY) begin m_pg <= 0; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end else if (!m_pg) m_cnt <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(1); tick = 1'b0; step(1);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    step(3);
    chk(pg_ok == 1'b0, "R8 flag", pg_ok, 0);
    chk(setpoint_mv == 0, "R8 setpoint", setpoint_mv, 0);
    rst_n = 1'b1;
    step(1);

    vid_code = 5'd30; enable = 1'b1; fb_mv = 12'd1100;
    step(1);
    chk(setpoint_mv == 1100, "R1 code30", setpoint_mv, 1100);
    step(1);
    chk(pg_ok == 1'b1, "R4 rise", pg_ok, 1);
    vid_code = 5'd0; step(1);
    chk(setpoint_mv == 1850, "R9 follow code0", setpoint_mv, 1850);
    vid_code = 5'd15; fb_mv = 12'd1400; step(1);
    chk(setpoint_mv == 1475, "R1 code15", setpoint_mv, 1475);
    step(2);
    chk(pg_ok == 1'b1, "R4 hold good", pg_ok, 1);

    // Fault delay: 1297 is below 88% of 1475 (1298).
    fb_mv = 12'd1297; step(2);
    pulse_ticks(DLY - 1);
    chk(pg_ok == 1'b1, "R5 before limit", pg_ok, 1);
    tick = 1'b1; step(1); tick = 1'b0;
    chk(pg_ok == 1'b0, "R5 at limit", pg_ok, 0);
    step(3);
    chk(pg_ok == 1'b0, "R3 below threshold", pg_ok, 0);
    fb_mv = 12'd1298; step(2);
    chk(pg_ok == 1'b1, "R3 equal threshold", pg_ok, 1);

    // Restart after one good cycle.
    fb_mv = 12'd1000; step(2);
    pulse_ticks(DLY - 1);
    fb_mv = 12'd1400; step(1); fb_mv = 12'd1000; step(2);
    pulse_ticks(DLY - 1);
    chk(pg_ok == 1'b1, "R6 restarted count", pg_ok, 1);
    pulse_ticks(1);
    chk(pg_ok == 1'b0, "R6 fall after full count", pg_ok, 0);

    fb_mv = 12'd1400; step(2);
    vid_code = 5'd31; step(1);
    chk(setpoint_mv == 0, "R2 off setpoint", setpoint_mv, 0);
    step(1);
    chk(pg_ok == 1'b0, "R2 off flag", pg_ok, 0);
    vid_code = 5'd15; step(2);
    chk(pg_ok == 1'b1, "R4 recover", pg_ok, 1);
    enable = 1'b0; step(2);
    chk(pg_ok == 1'b0, "R7 disable", pg_ok, 0);
    step(5);
    chk(pg_ok == 1'b0, "R7 stays low", pg_ok, 0);
    enable = 1'b1; step(2);

    for (int i = 0; i < 4000; i++) begin
      int sp;
      chk(pg_ok == m_pg, "R5 random flag", pg_ok, m_pg);
      chk(int'(setpoint_mv) == m_sp, "R9 random setpoint", setpoint_mv, m_sp);
      if ($urandom % 25 == 0) vid_code = 5'($urandom);
      if ($urandom % 60 == 0) enable = ~enable;
      if (!enable && $urandom % 4 == 0) enable = 1'b1;
      sp = exp_sp(vid_code);
      if (sp == 0) fb_mv = MV_W'($urandom % 2000);
      else fb_mv = MV_W'(sp * 85 / 100 + int'($urandom % 32'(sp * 16 / 100 + 1)));
      tick = ($urandom % 3 == 0);
      step(1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule